// File: doc/BRIEF.md
# Staggered Double-Capture Test Clock Controller

This block drives the gated test clocks of a multi-domain logic self-test. It has one gated clock output per clock domain and a single scan enable shared by all domains. In shift mode every domain is pulsed from the controller clock while scan enable is high. When the programmed shift length has been applied, scan enable falls. After a settle delay the domains are captured one after another in a fixed order. Each domain receives a pair of pulses taken from its own functional clock, so the pair is exactly one functional period apart and no clock is stretched or shortened. The rising edge of a domain's second pulse triggers the next domain through a two-flop synchronizer in the receiving domain. Once the last domain's second pulse has been seen back in the controller domain, scan enable rises. A second settle delay follows before the next shift burst.

The slow scan enable never changes near a capture pulse, so it can be routed as an ordinary low-speed net. The controller repeats the shift/capture loop a programmed number of times and then raises a finish flag. Shift length, settle length and iteration count are sampled when a run starts.

Top module: `dcap_clock_ctrl`

## Requirements
- R1: After reset, scan_en is 1 and finish is 0, and no pulse appears on any test_clk output until start is asserted.
- R2: In every iteration each domain receives exactly shift_len pulses (one if shift_len is 0) while scan_en is 1. These are gated copies of clk.
- R3: scan_en falls only after the last shift pulse of an iteration. The first capture pulse follows the fall of scan_en by at least settle_len+1 clk periods.
- R4: In every iteration each domain receives exactly two capture pulses while scan_en is 0, spaced by exactly one period of that domain's func_clk.
- R5: Capture pulses arrive domain by domain in index order 0, 1, ..., NUM_DOM-1. Domain i+1's first pulse comes only after domain i's second pulse, and the pairs never interleave.
- R6: scan_en rises only after the last domain's second capture pulse. The next shift pulse follows that rise by at least settle_len+1 clk periods.
- R7: finish rises once iter_count iterations (one if iter_count is 0) have completed. scan_en is 1 when this happens and no further pulses occur. finish stays high until the next start, which clears it.
- R8: shift_len, settle_len and iter_count are captured on the start cycle, and any change to them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and shift clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or finished |
| shift_len | input | LEN_W | Shift pulses per iteration (0 treated as 1) |
| settle_len | input | SET_W | Extra clk cycles waited after each scan enable change |
| iter_count | input | ITER_W | Shift/capture iterations per run (0 treated as 1) |
| func_clk | input | NUM_DOM | Functional clock of each domain |
| test_clk | output | NUM_DOM | Gated test clock of each domain |
| scan_en | output | 1 | Shared scan enable, high in shift mode |
| finish | output | 1 | High once the programmed iterations are done |

## Verification
Directed runs cover three boundary cases: a zero shift length and a zero iteration count, which must behave as one, and a zero settle length, which pulls capture as close to scan-enable edges as the design allows. A long run with several iterations shows that the pulse counts reset per iteration rather than per run. Seeded random runs vary all three settings. Mid-run changes to the inputs separate captured configuration from live input. The functional clocks run at unrelated periods, so an ordering fault, a third or missing capture pulse, or a pair spaced by the wrong clock shows up as a timing mismatch.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

    parameter int LEN_W  = 12;
    parameter int SET_W  = 8;
    parameter int ITER_W = 12;
    localparam int CNT_W = (LEN_W > SET_W) ? LEN_W : SET_W;

    typedef enum logic [2:0] {
        C_IDLE,
        C_SHIFT,
        C_SET_LO,
        C_CAPT,
        C_SET_HI,
        C_DONE
    } ctl_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_P1,
        S_P2,
        S_HOLD
    } stg_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [SET_W-1:0]  settle;
        logic [ITER_W-1:0] iters;
    } run_cfg_t;

    function automatic run_cfg_t make_cfg(input logic [LEN_W-1:0]  len,
                                          input logic [SET_W-1:0]  settle,
                                          input logic [ITER_W-1:0] iters);
        run_cfg_t c;
        c.len    = (len == '0) ? LEN_W'(1) : len;
        c.settle = settle;
        c.iters  = (iters == '0) ? ITER_W'(1) : iters;
        return c;
    endfunction

endpackage

// File: rtl/dcap_capture_stage.sv
module dcap_capture_stage
    import dcap_pkg::*;
(
    input  logic rst,
    input  logic fclk,
    input  logic trig,
    output logic cap_gate,
    output logic done
);

    logic       rst_meta, rst_q;
    logic       trig_meta, trig_s;
    stg_state_e st;
    logic       gate_n;

    always_ff @(posedge fclk) begin
        rst_meta <= rst;
        rst_q    <= rst_meta;
    end

    always_ff @(posedge fclk) begin
        if (rst_q) begin
            trig_meta <= 1'b0;
            trig_s    <= 1'b0;
        end else begin
            trig_meta <= trig;
            trig_s    <= trig_meta;
        end
    end

    always_ff @(posedge fclk) begin
        if (rst_q) begin
            st <= S_IDLE;
        end else begin
            case (st)
                S_IDLE:  if (trig_s)  st <= S_P1;
                S_P1:    st <= S_P2;
                S_P2:    st <= S_HOLD;
                S_HOLD:  if (!trig_s) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // enable changes only while the functional clock is low
    always_ff @(negedge fclk) begin
        if (rst_q) gate_n <= 1'b0;
        else       gate_n <= (st == S_P1) || (st == S_P2);
    end

    assign cap_gate = gate_n;
    assign done     = (st == S_HOLD);

    assert_gate_needs_trig_R5: assert property (@(posedge fclk) disable iff (rst_q)
        ((st == S_P1) || (st == S_P2)) |-> trig_s);

    assert_pair_back_to_back_R4: assert property (@(posedge fclk) disable iff (rst_q)
        (st == S_P2) |-> ($past(st) == S_P1));

endmodule

// File: rtl/dcap_sequencer.sv
module dcap_sequencer
    import dcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  shift_len,
    input  logic [SET_W-1:0]  settle_len,
    input  logic [ITER_W-1:0] iter_count,
    input  logic              chain_done,
    output logic              cap_req,
    output logic              shift_gate,
    output logic              scan_en,
    output logic              finish
);

    ctl_state_e        st;
    run_cfg_t          cfg;
    logic [CNT_W-1:0]  cnt;
    logic [ITER_W-1:0] iter;
    logic              done_meta, done_s;
    logic              sh_gate_n;

    wire shift_last  = (cnt == CNT_W'(cfg.len) - CNT_W'(1));
    wire settle_over = (cnt == CNT_W'(cfg.settle));

    always_ff @(posedge clk) begin
        if (rst) begin
            done_meta <= 1'b0;
            done_s    <= 1'b0;
        end else begin
            done_meta <= chain_done;
            done_s    <= done_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= C_IDLE;
            cfg     <= '0;
            cnt     <= '0;
            iter    <= '0;
            cap_req <= 1'b0;
            scan_en <= 1'b1;
            finish  <= 1'b0;
        end else begin
            case (st)
                C_IDLE, C_DONE: begin
                    if (start) begin
                        cfg    <= make_cfg(shift_len, settle_len, iter_count);
                        cnt    <= '0;
                        iter   <= '0;
                        finish <= 1'b0;
                        st     <= C_SHIFT;
                    end
                end
                C_SHIFT: begin
                    if (shift_last) begin
                        cnt     <= '0;
                        scan_en <= 1'b0;
                        st      <= C_SET_LO;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                C_SET_LO: begin
                    if (settle_over) begin
                        cap_req <= 1'b1;
                        st      <= C_CAPT;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                C_CAPT: begin
                    if (done_s) begin
                        cap_req <= 1'b0;
                        scan_en <= 1'b1;
                        cnt     <= '0;
                        st      <= C_SET_HI;
                    end
                end
                C_SET_HI: begin
                    if (!settle_over) begin
                        cnt <= cnt + CNT_W'(1);
                    end else if (!done_s) begin
                        cnt <= '0;
                        if (iter == cfg.iters - ITER_W'(1)) begin
                            finish <= 1'b1;
                            st     <= C_DONE;
                        end else begin
                            iter <= iter + ITER_W'(1);
                            st   <= C_SHIFT;
                        end
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    always_ff @(negedge clk) begin
        if (rst) sh_gate_n <= 1'b0;
        else     sh_gate_n <= (st == C_SHIFT);
    end

    assign shift_gate = sh_gate_n;

    assert_capture_under_low_se_R3: assert property (@(posedge clk) disable iff (rst)
        cap_req |-> !scan_en);

    assert_shift_under_high_se_R2: assert property (@(posedge clk) disable iff (rst)
        shift_gate |-> scan_en);

    assert_finish_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        finish |-> (scan_en && !cap_req && !shift_gate));

    assert_se_rise_after_chain_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_en) |-> $past(done_s));

endmodule

// File: rtl/dcap_clock_ctrl.sv
module dcap_clock_ctrl
    import dcap_pkg::*;
#(
    parameter int NUM_DOM = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  shift_len,
    input  logic [SET_W-1:0]  settle_len,
    input  logic [ITER_W-1:0] iter_count,
    input  logic [NUM_DOM-1:0] func_clk,
    output logic [NUM_DOM-1:0] test_clk,
    output logic              scan_en,
    output logic              finish
);

    logic               cap_req;
    logic               shift_gate;
    logic [NUM_DOM-1:0] stage_done;
    logic [NUM_DOM-1:0] stage_gate;
    logic [NUM_DOM-1:0] stage_trig;

    dcap_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .shift_len  (shift_len),
        .settle_len (settle_len),
        .iter_count (iter_count),
        .chain_done (stage_done[NUM_DOM-1]),
        .cap_req    (cap_req),
        .shift_gate (shift_gate),
        .scan_en    (scan_en),
        .finish     (finish)
    );

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        if (g == 0) begin : g_head
            assign stage_trig[g] = cap_req;
        end else begin : g_link
            assign stage_trig[g] = stage_done[g-1];
        end

        dcap_capture_stage u_stage (
            .rst      (rst),
            .fclk     (func_clk[g]),
            .trig     (stage_trig[g]),
            .cap_gate (stage_gate[g]),
            .done     (stage_done[g])
        );

        // the two gates are never open together: settle gaps separate them
        assign test_clk[g] = (func_clk[g] & stage_gate[g]) | (clk & shift_gate);
    end

endmodule

// File: tb/dcap_clock_ctrl_tb.sv
`timescale 1ns/1ps
module dcap_clock_ctrl_tb;
    import dcap_pkg::*;

    localparam int ND = 3;
    localparam real CLK_P = 8.0;
    localparam real P0 = 5.0, P1 = 7.0, P2 = 11.0;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic fc0 = 1'b0, fc1 = 1'b0, fc2 = 1'b0;
    logic [LEN_W-1:0]  shift_len = '0;
    logic [SET_W-1:0]  settle_len = '0;
    logic [ITER_W-1:0] iter_count = '0;
    logic [ND-1:0] func_clk, test_clk;
    logic scan_en, finish;

    assign func_clk = {fc2, fc1, fc0};

    always #(CLK_P/2) clk = ~clk;
    always #(P0/2) fc0 = ~fc0;
    always #(P1/2) fc1 = ~fc1;
    always #(P2/2) fc2 = ~fc2;

    dcap_clock_ctrl #(.NUM_DOM(ND)) u_dut (
        .clk(clk), .rst(rst), .start(start), .shift_len(shift_len),
        .settle_len(settle_len), .iter_count(iter_count), .func_clk(func_clk),
        .test_clk(test_clk), .scan_en(scan_en), .finish(finish)
    );

    // expectations, written only by the main process
    int exp_len = 1, exp_set = 0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic real dom_period(input int d);
        return (d == 0) ? P0 : ((d == 1) ? P1 : P2);
    endfunction

    // ---------------- monitor (its own counters) ----------------
    logic se_q = 1'b1;
    always @(negedge clk) se_q <= scan_en;

    int mon_checks = 0, mon_fails = 0;
    int falls = 0, total_pulses = 0;
    int sh_cnt [ND];
    int cap_cnt [ND];
    realtime t_first [ND];
    realtime t_fall = 0, t_rise = 0, t_last_cap = 0;
    int cap_seq = 0;
    bit after_rise = 0;
    logic [ND-1:0] prev_t = '0;
    logic prev_se = 1'b1;

    initial begin
        for (int d = 0; d < ND; d++) begin
            sh_cnt[d] = 0; cap_cnt[d] = 0; t_first[d] = 0;
        end
    end

    always @(test_clk or scan_en) begin
        if (!rst) begin
            if (prev_se === 1'b1 && scan_en === 1'b0) begin
                t_fall = $realtime;
                falls++;
            end
            if (prev_se === 1'b0 && scan_en === 1'b1) begin
                for (int d = 0; d < ND; d++) begin
                    mon_checks++;
                    if (cap_cnt[d] != 2) begin
                        mon_fails++;
                        $display("FAIL R4 dom %0d capture pulses actual %0d expected 2", d, cap_cnt[d]);
                    end
                    cap_cnt[d] = 0;
                end
                mon_checks++;
                if (!($realtime > t_last_cap)) begin
                    mon_fails++;
                    $display("FAIL R6 scan_en rise at %0t not after last capture %0t", $realtime, t_last_cap);
                end
                t_rise = $realtime;
                cap_seq = 0;
                after_rise = 1;
            end
            for (int d = 0; d < ND; d++) begin
                if (test_clk[d] === 1'b1 && prev_t[d] !== 1'b1) begin
                    total_pulses++;
                    if (se_q === 1'b1) begin
                        sh_cnt[d]++;
                        if (after_rise) begin
                            mon_checks++;
                            if ($realtime - t_rise < (exp_set + 1) * CLK_P - 0.01) begin
                                mon_fails++;
                                $display("FAIL R6 shift gap actual %0t expected >= %0t",
                                         $realtime - t_rise, (exp_set + 1) * CLK_P);
                            end
                        end
                    end else begin
                        mon_checks++;
                        if (d != (cap_seq / 2) % ND) begin
                            mon_fails++;
                            $display("FAIL R5 capture %0d on dom actual %0d expected %0d",
                                     cap_seq, d, (cap_seq / 2) % ND);
                        end
                        if (cap_seq == 0) begin
                            for (int k = 0; k < ND; k++) begin
                                mon_checks++;
                                if (sh_cnt[k] != exp_len) begin
                                    mon_fails++;
                                    $display("FAIL R2 dom %0d shift pulses actual %0d expected %0d",
                                             k, sh_cnt[k], exp_len);
                                end
                                sh_cnt[k] = 0;
                            end
                            mon_checks++;
                            if ($realtime - t_fall < (exp_set + 1) * CLK_P - 0.01) begin
                                mon_fails++;
                                $display("FAIL R3 capture gap actual %0t expected >= %0t",
                                         $realtime - t_fall, (exp_set + 1) * CLK_P);
                            end
                        end
                        cap_cnt[d]++;
                        if (cap_cnt[d] == 2) begin
                            mon_checks++;
                            if ($realtime - t_first[d] > dom_period(d) + 0.01 ||
                                $realtime - t_first[d] < dom_period(d) - 0.01) begin
                                mon_fails++;
                                $display("FAIL R4 dom %0d spacing actual %0t expected %0t",
                                         d, $realtime - t_first[d], dom_period(d));
                            end
                        end else begin
                            t_first[d] = $realtime;
                        end
                        cap_seq++;
                        t_last_cap = $realtime;
                    end
                end
            end
            after_rise = after_rise && (se_q !== 1'b1 || test_clk == '0);
        end
        prev_se = scan_en;
        prev_t  = test_clk;
    end

    // ---------------- main ----------------
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int len, input int set, input int n);
        int f0, p0, wd;
        shift_len  = LEN_W'(len);
        settle_len = SET_W'(set);
        iter_count = ITER_W'(n);
        exp_len = eff(len);
        exp_set = set;
        f0 = falls;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R8: disturb the live inputs; the run must keep its captured values
        shift_len  = LEN_W'($urandom_range(0, 20));
        settle_len = SET_W'($urandom_range(0, 9));
        iter_count = ITER_W'($urandom_range(0, 6));
        check(finish == 1'b0, "R7 finish cleared by start", int'(finish), 0);
        wd = 0;
        while (finish !== 1'b1 && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        check(wd < 20000, "R7 watchdog", wd, 0);
        check(falls - f0 == eff(n), "R7/R8 iterations before finish", falls - f0, eff(n));
        check(scan_en == 1'b1, "R7 scan_en at finish", int'(scan_en), 1);
        p0 = total_pulses;
        repeat (30) @(negedge clk);
        check(total_pulses == p0, "R7 quiet after finish", total_pulses - p0, 0);
        check(finish == 1'b1, "R7 finish held", int'(finish), 1);
    endtask

    initial begin
        int p0, seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (12) @(negedge clk);
        rst = 1'b0;
        check(scan_en == 1'b1, "R1 scan_en after reset", int'(scan_en), 1);
        check(finish == 1'b0, "R1 finish after reset", int'(finish), 0);
        p0 = total_pulses;
        repeat (25) @(negedge clk);
        check(total_pulses == p0, "R1 no pulses while idle", total_pulses - p0, 0);

        run(3, 0, 1);   // minimal settle
        run(0, 2, 2);   // zero shift length acts as one
        run(1, 0, 0);   // zero iteration count acts as one
        run(8, 5, 3);   // per-iteration counts across several loops
        for (int i = 0; i < 6; i++)
            run($urandom_range(1, 10), $urandom_range(0, 6), $urandom_range(1, 4));

        checks += mon_checks;
        fails  += mon_fails;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

endmodule